// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a processor's cache and main memory and takes in processor writes at core speed. Each accepted write is an address and data pair that lands in a small queue. Because the write is posted, the processor goes on executing while the queue drains to memory in the background, one write at a time, oldest first. The processor is held back only when every slot is occupied.

Reads that would bypass the queue must not see stale memory. A read address is therefore compared with every occupied slot. While any of them holds the same address, the read is refused until that write has been accepted by memory. No data is forwarded out of the queue. An empty flag lets flush or barrier logic wait until everything has reached memory.

Both data interfaces are valid/ready. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high; a low `wr_ready` is the processor stall. The memory side raises `mem_valid` whenever the queue holds data and keeps address and data unchanged until `mem_ready` is seen high on an edge. `rd_ready` is a permission signal that depends only on `rd_addr` and the queue contents.

Top module: `wbuf_post`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `mem_valid`=0, `wr_ready`=1 and `rd_ready`=1 for any read address.
- R2: While fewer than DEPTH entries are held, `wr_ready` is 1 and a write is accepted on the edge where `wr_valid` is high, whatever the memory side is doing.
- R3: With DEPTH entries held and no memory handshake in the same cycle, `wr_ready` is 0, `full` is 1 and a presented write is not taken.
- R4: Entries are offered on `mem_addr`/`mem_data` strictly in the order they were accepted.
- R5: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle still has `mem_valid`=1 with `mem_addr` and `mem_data` unchanged; an entry leaves only on a `mem_valid`&&`mem_ready` edge.
- R6: When the queue is full and memory accepts the head in the same cycle, `wr_ready` is 1, the new write is accepted and the queue stays full.
- R7: `rd_ready` is 0 while any held entry, including a head being accepted by memory this cycle, has an address equal to `rd_addr`; it is 1 otherwise. A write being accepted in the same cycle is not compared.
- R8: `empty` is 1 exactly when no entries are held, `mem_valid` equals the inverse of `empty`, and `full` is 1 exactly when DEPTH entries are held.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Processor offers a write |
| wr_ready | output | 1 | Write can be taken this cycle; low stalls the processor |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data word |
| rd_addr | input | ADDR_W | Address of a read about to go to memory |
| rd_ready | output | 1 | Read may proceed: no held write to the same address |
| mem_valid | output | 1 | Head entry is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | ADDR_W | Address of the head entry |
| mem_data | output | DATA_W | Data of the head entry |
| empty | output | 1 | No entries held |
| full | output | 1 | All DEPTH entries held |

## Verification
Directed phases fill the queue with memory stalled, push into the full queue with and without a same-cycle drain, and then drain it, which separates the stall condition from the full-with-pop case and shows the order entries leave. Reads are aimed at addresses just written, at the head while it is being accepted, and at addresses never written, so a compare that misses an entry or holds one too long shows up. A long random phase draws write and read addresses from a small pool so hits are common, with memory acceptance rates from rare to constant, and checks every output every cycle against a queue model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Pointer width for a ring of the given depth (at least one bit).
  function automatic int unsigned ptr_bits(input int unsigned depth);
    int unsigned b;
    b = 1;
    while ((1 << b) < depth) b++;
    return b;
  endfunction

  // Occupancy counter width able to hold 0..depth.
  function automatic int unsigned cnt_bits(input int unsigned depth);
    int unsigned b;
    b = 1;
    while ((1 << b) <= depth) b++;
    return b;
  endfunction

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = ptr_bits(DEPTH),
  localparam int unsigned CW = cnt_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PW-1:0]    put_idx,
  output logic [PW-1:0]    head_idx,
  output logic [DEPTH-1:0] occ,
  output logic             is_empty,
  output logic             is_full
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);

  logic [CW-1:0] level;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_idx  <= '0;
      head_idx <= '0;
      level    <= '0;
    end else begin
      if (push) put_idx  <= step(put_idx);
      if (pop)  head_idx <= step(head_idx);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  // Per-slot occupancy: clear on retire first, then set on store, so a
  // slot that is retired and refilled in one cycle stays occupied.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i] <= 1'b0;
        end else if (push && put_idx == PW'(i)) begin
          occ[i] <= 1'b1;
        end else if (pop && head_idx == PW'(i)) begin
          occ[i] <= 1'b0;
        end
      end
    end
  endgenerate

  assign is_empty = (level == '0);
  assign is_full  = (level == TOP);

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [PW-1:0]           put_idx,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [PW-1:0]           head_idx,
  output logic [ADDR_W-1:0]       head_addr,
  output logic [DATA_W-1:0]       head_data,
  output logic [DEPTH*ADDR_W-1:0] all_addr
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_addr[i] <= '0;
          slot_data[i] <= '0;
        end else if (push && put_idx == PW'(i)) begin
          slot_addr[i] <= in_addr;
          slot_data[i] <= in_data;
        end
      end
      assign all_addr[i*ADDR_W +: ADDR_W] = slot_addr[i];
    end
  endgenerate

  always_comb begin
    head_addr = '0;
    head_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (head_idx == PW'(i)) begin
        head_addr = slot_addr[i];
        head_data = slot_data[i];
      end
    end
  end

endmodule

// File: rtl/wbuf_hazard.sv
module wbuf_hazard #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [DEPTH*ADDR_W-1:0] all_addr,
  input  logic [DEPTH-1:0]        occ,
  input  logic [ADDR_W-1:0]       probe_addr,
  output logic                    clash
);

  logic [DEPTH-1:0] hit;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit[i] = occ[i] && (all_addr[i*ADDR_W +: ADDR_W] == probe_addr);
    end
  endgenerate

  assign clash = |hit;

endmodule

// File: rtl/wbuf_post.sv
module wbuf_post
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              empty,
  output logic              full
);

  localparam int unsigned PW = ptr_bits(DEPTH);

  logic              push, pop, clash;
  logic [PW-1:0]     put_idx, head_idx;
  logic [DEPTH-1:0]  occ;
  logic [DEPTH*ADDR_W-1:0] all_addr;

  assign mem_valid = !empty;
  assign pop       = mem_valid && mem_ready;
  // A full queue still takes a write when the head leaves this cycle.
  assign wr_ready  = !full || pop;
  assign push      = wr_valid && wr_ready;
  assign rd_ready  = !clash;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .put_idx  (put_idx),
    .head_idx (head_idx),
    .occ      (occ),
    .is_empty (empty),
    .is_full  (full)
  );

  wbuf_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW(PW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .put_idx   (put_idx),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .head_idx  (head_idx),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .all_addr  (all_addr)
  );

  wbuf_hazard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hazard (
    .all_addr   (all_addr),
    .occ        (occ),
    .probe_addr (rd_addr),
    .clash      (clash)
  );

endmodule

// File: rtl/wbuf_post_chk.sv
module wbuf_post_chk
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              empty,
  input logic              full
);

  localparam int unsigned CW = cnt_bits(DEPTH);

  // Occupancy rebuilt from port handshakes only.
  logic [CW-1:0] seen;
  logic          acc_w, acc_m;
  assign acc_w = wr_valid && wr_ready;
  assign acc_m = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (acc_w && !acc_m) seen <= seen + 1'b1;
    else if (acc_m && !acc_w) seen <= seen - 1'b1;
  end

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty == (seen == '0)) && (full == (seen == CW'(DEPTH))) && (mem_valid == !empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !mem_ready) |-> !wr_ready);

  p_full_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && mem_ready && wr_valid) |=> full);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_block_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> ((rd_addr == $past(wr_addr)) -> !rd_ready));

  p_empty_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> rd_ready);

  p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> wr_ready);

endmodule

bind wbuf_post wbuf_post_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wbuf_post_test.sv
module wbuf_post_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, mem_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, rd_ready, mem_valid, empty, full;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_post #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [ADDR_W-1:0] q_a [$];
  logic [DATA_W-1:0] q_d [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic bit model_clash(input logic [ADDR_W-1:0] a);
    foreach (q_a[i]) if (q_a[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: inputs already driven after a falling edge; check, then advance model.
  task automatic cycle_check();
    bit pop_e, push_e;
    #1;
    chk("R8 empty", empty, q_a.size() == 0);
    chk("R8 full", full, q_a.size() == DEPTH);
    chk("R8 mem_valid", mem_valid, q_a.size() != 0);
    pop_e  = (q_a.size() != 0) && mem_ready;
    chk(q_a.size() == DEPTH ? (pop_e ? "R6 wr_ready" : "R3 wr_ready") : "R2 wr_ready",
        wr_ready, (q_a.size() < DEPTH) || pop_e);
    chk("R7 rd_ready", rd_ready, !model_clash(rd_addr));
    if (q_a.size() != 0) begin
      chk("R4 mem_addr", mem_addr, q_a[0]);
      chk("R4 mem_data", mem_data, q_d[0]);
    end
    push_e = wr_valid && ((q_a.size() < DEPTH) || pop_e);
    @(posedge clk);
    if (pop_e) begin void'(q_a.pop_front()); void'(q_d.pop_front()); end
    if (push_e) begin q_a.push_back(wr_addr); q_d.push_back(wr_data); end
    cycles++;
    @(negedge clk);
  endtask

  task automatic drive(input bit wv, input logic [ADDR_W-1:0] wa, input logic [DATA_W-1:0] wd,
                       input logic [ADDR_W-1:0] ra, input bit mr);
    wr_valid = wv; wr_addr = wa; wr_data = wd; rd_addr = ra; mem_ready = mr;
    cycle_check();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 mem_valid", mem_valid, 0); chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: fill with memory stalled, then push against a full queue
    for (int i = 0; i < DEPTH; i++) drive(1, 32'h100 + i*4, 32'hA000 + i, 32'h100, 0);
    drive(1, 32'h900, 32'hBAD, 32'h900, 0);           // R3 stall, R7 0x900 not held
    chk("R3 full after refused write", full, 1);
    // R5: head held while memory stalls
    drive(0, 0, 0, 32'h11C, 0);                        // R7 last entry blocks
    // R6: push with pop while full
    drive(1, 32'h200, 32'hC000, 32'h100, 1);           // R7 head being accepted still blocks
    chk("R6 still full", full, 1);
    drive(0, 0, 0, 32'h100, 0);                        // R7 retired head no longer blocks
    // R4/R8: drain completely
    while (q_a.size() != 0) drive(0, 0, 0, 32'h200, 1);
    chk("R8 empty after drain", empty, 1);
    drive(0, 0, 0, 32'h200, 1);

    // Random phase with a small address pool so read hits are common
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        int unsigned pr;
        pr = (ph == 0) ? 10 : (ph == 1) ? 40 : (ph == 2) ? 75 : 100;
        drive(($urandom % 100) < 60, ($urandom % 12) * 4, $urandom,
              ($urandom % 12) * 4, ($urandom % 100) < pr);
      end
    end
    while (q_a.size() != 0) drive(0, 0, 0, 0, 1);
    chk("R8 final empty", empty, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule